// File: doc/BRIEF.md
# Byte and Pair Increment/Decrement Flag Unit

This unit adds one to or subtracts one from a value and keeps the condition flags of a small accumulator machine. In byte mode it works on the low eight bits of the operand and sets the zero, subtract and half-carry flags from the result. In pair mode it works on the full sixteen bits, for a register pair or stack pointer, and leaves those flags untouched.

The carry flag is never produced by this unit. The caller's current carry is copied to the carry output on every operation, so a flag bank fed from the unit keeps its carry unchanged.

A request is accepted on a rising clock edge while `valid_i` is high. The result and the flags are registered and appear after that edge. Without a request, every output holds its value.

Top module: `incdec_flag_unit`

## Requirements
- R1: After a byte operation, `zero_o` is 1 exactly when `result_o[7:0]` equals 0x00.
- R2: After a byte operation, `sub_o` is 0 for an increment (`dec_i`=0) and 1 for a decrement (`dec_i`=1).
- R3: After a byte increment, `half_o` is 1 exactly when `result_o[3:0]` equals 0x0.
- R4: After a byte decrement, `half_o` is 1 exactly when `result_o[3:0]` equals 0xF.
- R5: A byte operation wraps modulo 256 (0xFF+1=0x00, 0x00-1=0xFF). `operand_i[15:8]` is ignored and `result_o[15:8]` reads 0x00.
- R6: A pair operation (`wide_i`=1) increments or decrements all sixteen bits modulo 65536 (0xFFFF+1=0x0000, 0x0000-1=0xFFFF).
- R7: A pair operation leaves `zero_o`, `sub_o` and `half_o` unchanged.
- R8: After every accepted operation of either width, `carry_o` equals the `carry_i` presented with it.
- R9: While `valid_i` is low, all outputs hold their values.
- R10: While `rst_ni` is low, `result_o` is 0x0000 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept an operation at this edge |
| wide_i | input | 1 | 1 = sixteen-bit pair operation, 0 = byte operation |
| dec_i | input | 1 | 1 = decrement, 0 = increment |
| operand_i | input | 16 | Value to modify (byte mode uses bits 7:0) |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 16 | Registered result |
| zero_o | output | 1 | Zero flag |
| sub_o | output | 1 | Subtract flag |
| half_o | output | 1 | Half-carry flag |
| carry_o | output | 1 | Carry flag copied from the last operation |

## Verification
The bench drives the nibble boundaries that set half-carry: a byte increment landing on 0x10, and a byte decrement landing on 0x0F. A unit that takes half-carry from the wrong nibble value, or from the operand in place of the result, shows a wrong `half_o` there. It also drives both wrap points in both widths, and a byte operand with upper bits set, which catches carries that leak into the high byte. It runs pair operations right after byte operations that set the flags, which catches a pair path that writes Z, N or H, and it checks that `carry_o` follows `carry_i` in both widths.

// File: rtl/incdec_pkg.sv
package incdec_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned PAIR_W = 2 * BYTE_W;

  typedef struct packed {
    logic zero;
    logic sub;
    logic half;
  } arith_flags_t;
endpackage

// File: rtl/incdec_byte_core.sv
module incdec_byte_core #(
  parameter int unsigned W   = 8,
  parameter int unsigned NIB = 4
) (
  input  logic [W-1:0]             a_i,
  input  logic                     dec_i,
  output logic [W-1:0]             res_o,
  output incdec_pkg::arith_flags_t flags_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    res_o         = dec_i ? (a_i - ONE) : (a_i + ONE);
    flags_o.zero  = (res_o == '0);
    flags_o.sub   = dec_i;
    // half-carry read back from the result nibble: 0x0 after inc, all ones after dec
    flags_o.half  = dec_i ? (&res_o[NIB-1:0]) : ~(|res_o[NIB-1:0]);
  end
endmodule

// File: rtl/incdec_pair_core.sv
module incdec_pair_core #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic         dec_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign res_o = dec_i ? (a_i - ONE) : (a_i + ONE);
endmodule

// File: rtl/incdec_flag_unit.sv
module incdec_flag_unit
  import incdec_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned NW = NIB_W,
  localparam int unsigned PW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          wide_i,
  input  logic          dec_i,
  input  logic [PW-1:0] operand_i,
  input  logic          carry_i,
  output logic [PW-1:0] result_o,
  output logic          zero_o,
  output logic          sub_o,
  output logic          half_o,
  output logic          carry_o
);
  logic [BW-1:0] byte_res;
  logic [PW-1:0] pair_res;
  arith_flags_t  byte_flags;
  arith_flags_t  flags_q;

  incdec_byte_core #(.W(BW), .NIB(NW)) i_byte (
    .a_i     (operand_i[BW-1:0]),
    .dec_i   (dec_i),
    .res_o   (byte_res),
    .flags_o (byte_flags)
  );

  incdec_pair_core #(.W(PW)) i_pair (
    .a_i   (operand_i),
    .dec_i (dec_i),
    .res_o (pair_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flags_q  <= '0;
      carry_o  <= 1'b0;
    end else if (valid_i) begin
      carry_o <= carry_i;
      if (wide_i) begin
        result_o <= pair_res;
      end else begin
        result_o <= {{(PW-BW){1'b0}}, byte_res};
        flags_q  <= byte_flags;
      end
    end
  end

  assign zero_o = flags_q.zero;
  assign sub_o  = flags_q.sub;
  assign half_o = flags_q.half;

  assert_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> zero_o == (result_o[BW-1:0] == '0));
  assert_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> sub_o == $past(dec_i));
  assert_half_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i && !dec_i |=> half_o == (result_o[NW-1:0] == '0));
  assert_half_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i && dec_i |=> half_o == (&result_o[NW-1:0]));
  assert_high_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i |=> result_o[PW-1:BW] == '0);
  assert_flags_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_i |=> $stable({zero_o, sub_o, half_o}));
  assert_carry_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> carry_o == $past(carry_i));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({result_o, zero_o, sub_o, half_o, carry_o}));
endmodule

// File: tb/test_incdec_flag_unit.sv
`timescale 1ns/1ps
module test_incdec_flag_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        wide_i = 1'b0;
  logic        dec_i = 1'b0;
  logic [15:0] operand_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] result_o;
  logic        zero_o, sub_o, half_o, carry_o;

  int checks = 0;
  int failures = 0;
  logic exp_z = 1'b0, exp_n = 1'b0, exp_h = 1'b0;

  always #4 clk_i = ~clk_i;

  incdec_flag_unit i_incdec_flag_unit (
    .clk_i, .rst_ni, .valid_i, .wide_i, .dec_i, .operand_i, .carry_i,
    .result_o, .zero_o, .sub_o, .half_o, .carry_o
  );

  // {wide, dec, carry, operand, expected result}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 16'h0012, 16'h0013},  // R1 R2 plain inc
    {1'b0, 1'b0, 1'b1, 16'h000F, 16'h0010},  // R3 nibble rollover
    {1'b0, 1'b0, 1'b0, 16'h00FF, 16'h0000},  // R5 wrap, zero
    {1'b1, 1'b0, 1'b1, 16'h00FF, 16'h0100},  // R6 R7 after flags set
    {1'b0, 1'b1, 1'b0, 16'h0010, 16'h000F},  // R4 nibble borrow
    {1'b0, 1'b1, 1'b1, 16'h0000, 16'h00FF},  // R5 wrap down
    {1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000},  // R6 wrap, R7
    {1'b0, 1'b1, 1'b0, 16'h0001, 16'h0000},  // R1 zero on dec
    {1'b1, 1'b1, 1'b1, 16'h0000, 16'hFFFF},  // R6 wrap down, R8
    {1'b0, 1'b0, 1'b0, 16'hAB7E, 16'h007F},  // R5 upper byte ignored
    {1'b1, 1'b1, 1'b0, 16'h1200, 16'h11FF},  // R6 borrow across bytes
    {1'b0, 1'b1, 1'b0, 16'h0080, 16'h007F},  // R4 half on dec
    {1'b0, 1'b0, 1'b1, 16'h00EF, 16'h00F0}   // R3 inc to x0
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic d, input logic c, input logic [15:0] op);
    @(negedge clk_i);
    wide_i = w; dec_i = d; carry_i = c; operand_i = op; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10", "result", result_o, 16'h0000);
    check("R10", "flags", {12'h0, zero_o, sub_o, half_o, carry_o}, 16'h0000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic w, d, c;
      logic [15:0] op, er;
      {w, d, c, op, er} = VEC[i];
      run_op(w, d, c, op);
      if (!w) begin
        exp_z = (er[7:0] == 8'h00);
        exp_n = d;
        exp_h = d ? (er[3:0] == 4'hF) : (er[3:0] == 4'h0);
      end
      check(w ? "R6" : "R5", "result", result_o, er);
      check(w ? "R7" : "R1", "zero", {15'h0, zero_o}, {15'h0, exp_z});
      check(w ? "R7" : "R2", "sub", {15'h0, sub_o}, {15'h0, exp_n});
      check(w ? "R7" : (d ? "R4" : "R3"), "half", {15'h0, half_o}, {15'h0, exp_h});
      check("R8", "carry", {15'h0, carry_o}, {15'h0, c});
    end

    // R9: idle cycles with toggling inputs leave outputs alone
    @(negedge clk_i);
    wide_i = 1'b0; dec_i = 1'b1; carry_i = 1'b0; operand_i = 16'h0001;
    repeat (3) @(negedge clk_i);
    check("R9", "result", result_o, 16'h00F0);
    check("R9", "flags", {12'h0, zero_o, sub_o, half_o, carry_o}, {12'h0, exp_z, exp_n, exp_h, 1'b1});

    // R10: reset mid-run clears everything
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10", "result after reset", result_o, 16'h0000);
    check("R10", "flags after reset", {12'h0, zero_o, sub_o, half_o, carry_o}, 16'h0000);
    rst_ni = 1'b1;

    // R7: pair op straight after reset keeps cleared flags, R8 carry follows
    run_op(1'b1, 1'b1, 1'b1, 16'h0100);
    check("R6", "result", result_o, 16'h00FF);
    check("R7", "flags", {13'h0, zero_o, sub_o, half_o}, 16'h0000);
    check("R8", "carry", {15'h0, carry_o}, 16'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule